// File: doc/BRIEF.md
# LIN Break and Sync Field Handler

This block sits beside a UART and adds the framing that a LIN bus needs ahead of each frame header. On a master node it drives the transmit line dominant (low) for a fixed number of bit times when software asks for a break. It then releases the line for a delimiter of at least one bit time. On a slave node it watches the receive line for a low run long enough to be a break and raises a one-cycle break interrupt. It then marks the first and the last falling edge of the 0x55 sync byte that follows. An external timer uses those two marks to measure eight bit times and so the master's bit rate.

Bit timing comes from a single-cycle `bit_tick_i` strobe produced by the UART's baud generator. The receive input is assumed to be synchronised to `clk` already. Data handling and baud-rate adjustment stay in the UART. LIN frames always carry 8-bit data, so the sync byte has five falling edges, counting its start bit.

Top module: `lin_brk_sync`

## Requirements
- R1: While `master_i`=1 and no break is in progress, a request (`brk_req_i`=1 at a clock edge) sets `tx_brk_o` (1 = drive TX low) from the next cycle.
- R2: `tx_brk_o` stays 1 until the thirteenth `bit_tick_i` counted after the accepting edge, and it is 0 from the cycle after that tick.
- R3: After release, the block ignores requests until one more `bit_tick_i` has passed (the delimiter). It also ignores requests while a break is being sent and while `master_i`=0. A break in progress completes even if `master_i` falls.
- R4: With `master_i`=0 and detection armed, the block pulses `brk_irq_o` for one cycle after the edge at which the eleventh `bit_tick_i` is counted with `rx_i` low. A low run covering only ten ticks gives no pulse.
- R5: After a break is detected, no further break can be reported until `rx_i` has been seen high. Detection is also unarmed after reset until `rx_i` is seen high.
- R6: After a break, once `rx_i` has been seen high, the first clock edge that sees `rx_i` fall gives a one-cycle `sync_start_o` pulse in the following cycle.
- R7: The fifth falling edge of `rx_i` after the break, counting the start edge as the first, gives a one-cycle `sync_stop_o` pulse with the same one-cycle latency. For a 0x55 byte this is exactly eight bit times after `sync_start_o`.
- R8: While `master_i`=1, no `brk_irq_o`, `sync_start_o` or `sync_stop_o` pulse is produced.
- R9: During and straight after reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Synchronised receive line |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| master_i | input | 1 | 1 = master (generate), 0 = slave (detect) |
| brk_req_i | input | 1 | Break send request |
| tx_brk_o | output | 1 | 1 = force TX low for the break |
| brk_irq_o | output | 1 | Break-detected interrupt pulse |
| sync_start_o | output | 1 | Sync field start edge pulse to timer |
| sync_stop_o | output | 1 | Sync field stop edge pulse to timer |

## Verification
Every result here is one register deep. `tx_brk_o` changes in the cycle after the accepting edge or after the thirteenth tick. `brk_irq_o` follows the edge that counts the eleventh low tick by one cycle. The sync pulses follow by one cycle the edge that first sees `rx_i` low. The bench updates a reference model at each rising edge, in the same order of causes, and compares all four outputs at the falling edge, so each expected value is sampled in the cycle it is due. Directed cases also measure pulse counts, the break length in cycles and the 32-cycle gap between the sync marks at four clocks per bit.

// File: rtl/lin_brk_pkg.sv
// Package: shared state encodings for the LIN break/sync handler.
// Assumes: nothing beyond IEEE 1800-2017.
package lin_brk_pkg;

    // Break generator phases
    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_LOW   = 2'd1,
        GEN_DELIM = 2'd2
    } gen_st_t;

    // Sync field tracker phases
    typedef enum logic [1:0] {
        SYN_IDLE  = 2'd0,
        SYN_DELIM = 2'd1,
        SYN_START = 2'd2,
        SYN_MEAS  = 2'd3
    } syn_st_t;

endpackage

// File: rtl/lin_brk_gen.sv
// Module: lin_brk_gen
// Drives the break on the transmit side. An accepted request holds the
// line low for GEN_BITS bit ticks, then keeps it released for DELIM_BITS
// ticks before the next request can be taken.
// Assumes: bit_tick_i is a single-cycle strobe; the request is only taken
// in master mode, and a break that has started always runs to its end.
module lin_brk_gen
    import lin_brk_pkg::*;
#(
    parameter int GEN_BITS   = 13,
    parameter int DELIM_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick_i,
    input  logic master_i,
    input  logic brk_req_i,
    output logic tx_brk_o
);
    localparam int MAXB  = (GEN_BITS > DELIM_BITS) ? GEN_BITS : DELIM_BITS;
    localparam int CNT_W = $clog2(MAXB + 1);

    gen_st_t          state;
    logic [CNT_W-1:0] cnt;

    // Phase sequencing and bit-time counting for break generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GEN_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                GEN_IDLE: begin
                    if (master_i && brk_req_i) begin
                        state <= GEN_LOW;
                        cnt   <= '0;
                    end
                end
                GEN_LOW: begin
                    if (bit_tick_i) begin
                        if (cnt == CNT_W'(GEN_BITS - 1)) begin
                            state <= GEN_DELIM;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                GEN_DELIM: begin
                    if (bit_tick_i) begin
                        if (cnt == CNT_W'(DELIM_BITS - 1)) begin
                            state <= GEN_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= GEN_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Line is forced low only in the low phase (decoded from a register)
    always_comb tx_brk_o = (state == GEN_LOW);

endmodule

// File: rtl/lin_brk_det.sv
// Module: lin_brk_det
// Counts bit ticks while the receive line is low and reports a break once
// DET_BITS ticks have been seen. It reports once per low run: detection
// re-arms only when the line is seen high.
// Assumes: rx_i is already synchronised; it is disabled in master mode.
module lin_brk_det #(
    parameter int DET_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic bit_tick_i,
    input  logic master_i,
    output logic brk_irq_o
);
    localparam int CNT_W = $clog2(DET_BITS + 1);

    logic             armed;
    logic [CNT_W-1:0] low_cnt;

    // Low-run measurement, arming and break pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            low_cnt   <= '0;
            brk_irq_o <= 1'b0;
        end else begin
            brk_irq_o <= 1'b0;
            if (master_i) begin
                armed   <= 1'b0;
                low_cnt <= '0;
            end else if (rx_i) begin
                armed   <= 1'b1;
                low_cnt <= '0;
            end else if (armed && bit_tick_i) begin
                if (low_cnt == CNT_W'(DET_BITS - 1)) begin
                    brk_irq_o <= 1'b1;
                    armed     <= 1'b0;
                    low_cnt   <= '0;
                end else begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lin_sync_edge.sv
// Module: lin_sync_edge
// After a break report, waits for the delimiter (line high). It then marks
// the first falling edge as the sync start and the SYNC_FALLS-th falling
// edge as the sync stop, each with a one-cycle pulse.
// Assumes: rx_i is synchronised; a new break report restarts the tracker;
// master mode holds it idle.
module lin_sync_edge
    import lin_brk_pkg::*;
#(
    parameter int SYNC_FALLS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic master_i,
    input  logic brk_seen_i,
    output logic sync_start_o,
    output logic sync_stop_o
);
    localparam int CNT_W = $clog2(SYNC_FALLS + 1);

    syn_st_t          state;
    logic [CNT_W-1:0] falls;
    logic             rx_q;
    logic             fall;

    // Falling edge of the receive line against its previous sample
    always_comb fall = rx_q && !rx_i;

    // Previous-sample register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_i;
    end

    // Sync field phase tracking and edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SYN_IDLE;
            falls        <= '0;
            sync_start_o <= 1'b0;
            sync_stop_o  <= 1'b0;
        end else begin
            sync_start_o <= 1'b0;
            sync_stop_o  <= 1'b0;
            if (master_i) begin
                state <= SYN_IDLE;
                falls <= '0;
            end else if (brk_seen_i) begin
                state <= SYN_DELIM;
                falls <= '0;
            end else begin
                unique case (state)
                    SYN_IDLE: ;
                    SYN_DELIM: if (rx_i) state <= SYN_START;
                    SYN_START: begin
                        if (fall) begin
                            sync_start_o <= 1'b1;
                            falls        <= CNT_W'(1);
                            state        <= SYN_MEAS;
                        end
                    end
                    SYN_MEAS: begin
                        if (fall) begin
                            if (falls == CNT_W'(SYNC_FALLS - 1)) begin
                                sync_stop_o <= 1'b1;
                                falls       <= '0;
                                state       <= SYN_IDLE;
                            end else begin
                                falls <= falls + 1'b1;
                            end
                        end
                    end
                    default: state <= SYN_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/lin_brk_sync.sv
// Module: lin_brk_sync (top)
// LIN header framing helper for a UART: break generation in master mode,
// plus break detection and sync-field edge marking in slave mode.
// Assumes: bit_tick_i comes from the UART baud generator, rx_i is
// synchronised, and data is always 8 bits wide so the 0x55 sync byte has
// DATA_BITS/2 + 1 falling edges.
module lin_brk_sync #(
    parameter int DATA_BITS  = 8,
    parameter int DET_BITS   = 11,
    parameter int GEN_BITS   = 13,
    parameter int DELIM_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic bit_tick_i,
    input  logic master_i,
    input  logic brk_req_i,
    output logic tx_brk_o,
    output logic brk_irq_o,
    output logic sync_start_o,
    output logic sync_stop_o
);
    localparam int SYNC_FALLS = DATA_BITS / 2 + 1;

    logic brk_seen;

    lin_brk_gen #(
        .GEN_BITS   (GEN_BITS),
        .DELIM_BITS (DELIM_BITS)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick_i (bit_tick_i),
        .master_i   (master_i),
        .brk_req_i  (brk_req_i),
        .tx_brk_o   (tx_brk_o)
    );

    lin_brk_det #(
        .DET_BITS   (DET_BITS)
    ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .bit_tick_i (bit_tick_i),
        .master_i   (master_i),
        .brk_irq_o  (brk_seen)
    );

    lin_sync_edge #(
        .SYNC_FALLS (SYNC_FALLS)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx_i),
        .master_i     (master_i),
        .brk_seen_i   (brk_seen),
        .sync_start_o (sync_start_o),
        .sync_stop_o  (sync_stop_o)
    );

    // Break report doubles as the interrupt output
    always_comb brk_irq_o = brk_seen;

endmodule

// File: rtl/lin_brk_sync_chk.sv
// Checker for lin_brk_sync, attached by bind. Observes top-level ports only.
module lin_brk_sync_chk #(
    parameter int GEN_BITS = 13
) (
    input logic clk,
    input logic rst_n,
    input logic rx_i,
    input logic bit_tick_i,
    input logic master_i,
    input logic brk_req_i,
    input logic tx_brk_o,
    input logic brk_irq_o,
    input logic sync_start_o,
    input logic sync_stop_o
);
    localparam int CW = $clog2(GEN_BITS + 2);
    logic [CW-1:0] lo_ticks;

    // Ticks seen while the break is driven
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_brk_o) lo_ticks <= '0;
        else if (bit_tick_i)     lo_ticks <= lo_ticks + 1'b1;
    end

    a_r1_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_brk_o) |-> $past(brk_req_i && master_i));

    a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_brk_o) |-> $past(bit_tick_i));

    a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_brk_o |-> (lo_ticks < CW'(GEN_BITS)));

    a_r4_irq_rx_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq_o |-> $past(!rx_i && bit_tick_i));

    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq_o |=> !brk_irq_o);

    a_r6_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start_o |-> $past(!rx_i));

    a_r7_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({brk_irq_o, sync_start_o, sync_stop_o}));

    a_r8_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_i) |-> !(brk_irq_o || sync_start_o || sync_stop_o));

endmodule

bind lin_brk_sync lin_brk_sync_chk #(.GEN_BITS(GEN_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx_i),
    .bit_tick_i   (bit_tick_i),
    .master_i     (master_i),
    .brk_req_i    (brk_req_i),
    .tx_brk_o     (tx_brk_o),
    .brk_irq_o    (brk_irq_o),
    .sync_start_o (sync_start_o),
    .sync_stop_o  (sync_stop_o)
);

// File: tb/lin_brk_sync_tb.sv
// Bench for lin_brk_sync: reference model compared every cycle, plus
// directed counts and timings. Four clocks per bit time.
module lin_brk_sync_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic bit_tick = 1'b0;
    logic master = 1'b0;
    logic req = 1'b0;
    logic tx_brk, brk_irq, sync_start, sync_stop;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int cyc = 0;
    int tick_div = 0;

    lin_brk_sync u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .bit_tick_i(bit_tick),
        .master_i(master), .brk_req_i(req), .tx_brk_o(tx_brk),
        .brk_irq_o(brk_irq), .sync_start_o(sync_start), .sync_stop_o(sync_stop)
    );

    always #5 clk = ~clk;

    // bit tick: one cycle in four, driven away from the active edge
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        bit_tick = (tick_div == 0);
    end

    // ---------------- reference model (from the requirements) -------------
    int  g_st = 0, g_cnt = 0;
    bit  d_arm = 0;
    int  d_cnt = 0;
    bit  m_irq = 0, m_start = 0, m_stop = 0, m_rxq = 1;
    int  s_st = 0, s_n = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            g_st = 0; g_cnt = 0; d_arm = 0; d_cnt = 0;
            m_irq = 0; m_start = 0; m_stop = 0; m_rxq = 1; s_st = 0; s_n = 0;
        end else begin
            bit fall;
            fall = m_rxq && !rx;
            m_start = 0; m_stop = 0;
            if (master) s_st = 0;
            else if (m_irq) begin s_st = 1; s_n = 0; end
            else if (s_st == 1) begin if (rx) s_st = 2; end
            else if (s_st == 2) begin
                if (fall) begin m_start = 1; s_n = 1; s_st = 3; end
            end else if (s_st == 3) begin
                if (fall) begin
                    s_n++;
                    if (s_n == 5) begin m_stop = 1; s_st = 0; end
                end
            end
            m_rxq = rx;
            m_irq = 0;
            if (master) begin d_arm = 0; d_cnt = 0; end
            else if (rx) begin d_arm = 1; d_cnt = 0; end
            else if (d_arm && bit_tick) begin
                d_cnt++;
                if (d_cnt == 11) begin m_irq = 1; d_arm = 0; d_cnt = 0; end
            end
            if (g_st == 0) begin
                if (master && req) begin g_st = 1; g_cnt = 0; end
            end else if (bit_tick) begin
                g_cnt++;
                if (g_st == 1 && g_cnt == 13) begin g_st = 2; g_cnt = 0; end
                else if (g_st == 2 && g_cnt == 1) begin g_st = 0; g_cnt = 0; end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pulse counters and timestamps observed at the ports
    int n_irq = 0, n_start = 0, n_stop = 0, n_rise = 0, lo_cyc = 0;
    int t_start = 0, t_stop = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(tx_brk == (g_st == 1), "R1/R2/R3 tx_brk", tx_brk, g_st == 1);
            check(brk_irq == m_irq, "R4/R5/R8 brk_irq", brk_irq, m_irq);
            check(sync_start == m_start, "R6 sync_start", sync_start, m_start);
            check(sync_stop == m_stop, "R7 sync_stop", sync_stop, m_stop);
            if (brk_irq) n_irq++;
            if (sync_start) begin n_start++; t_start = cyc; end
            if (sync_stop) begin n_stop++; t_stop = cyc; end
            if (tx_brk) lo_cyc++;
        end
    end

    always @(posedge tx_brk) n_rise++;

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!bit_tick) @(posedge clk);
        end
    endtask

    task automatic hold(input bit lvl, input int n);
        @(negedge clk);
        rx = lvl;
        wait_ticks(n);
    endtask

    task automatic send55();
        hold(1'b0, 1);
        for (int b = 0; b < 8; b++) hold(((8'h55 >> b) & 1) != 0, 1);
        hold(1'b1, 1);
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check({tx_brk, brk_irq, sync_start, sync_stop} == 4'b0, "R9 reset outputs",
              {tx_brk, brk_irq, sync_start, sync_stop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({tx_brk, brk_irq, sync_start, sync_stop} == 4'b0, "R9 after reset",
              {tx_brk, brk_irq, sync_start, sync_stop}, 0);

        // R4: exactly 11 low ticks -> one break; R6/R7 sync marks
        hold(1'b1, 2);
        b0 = n_irq;
        hold(1'b0, 11);
        hold(1'b1, 1);
        check(n_irq - b0 == 1, "R4 11-bit low run", n_irq - b0, 1);
        b0 = n_start;
        send55();
        hold(1'b1, 2);
        check(n_start - b0 == 1, "R6 sync start count", n_start - b0, 1);
        check(t_stop - t_start == 32, "R7 start-to-stop cycles", t_stop - t_start, 32);

        // R4: 10 low ticks -> none
        b0 = n_irq;
        hold(1'b0, 10);
        hold(1'b1, 2);
        check(n_irq == b0, "R4 10-bit low run", n_irq - b0, 0);

        // R5: long low gives a single report
        b0 = n_irq;
        hold(1'b0, 30);
        hold(1'b1, 2);
        check(n_irq - b0 == 1, "R5 one report per low run", n_irq - b0, 1);

        // R8: master mode, long low, no reports
        @(negedge clk); master = 1'b1;
        b0 = n_irq + n_start + n_stop;
        hold(1'b0, 15);
        hold(1'b1, 1);
        send55();
        check(n_irq + n_start + n_stop == b0, "R8 master quiet", n_irq + n_start + n_stop - b0, 0);

        // R1/R2/R3: break length, request during break ignored
        hold(1'b1, 2);
        b0 = n_rise; lo_cyc = 0;
        pulse_req();
        wait_ticks(5);
        pulse_req();
        wait_ticks(12);
        check(n_rise - b0 == 1, "R3 request while sending ignored", n_rise - b0, 1);
        check(lo_cyc >= 49 && lo_cyc <= 52, "R2 break length cycles", lo_cyc, 52);
        // R3: slave-mode request ignored
        @(negedge clk); master = 1'b0;
        b0 = n_rise;
        pulse_req();
        wait_ticks(16);
        check(n_rise == b0, "R3 slave request ignored", n_rise - b0, 0);

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); master = ($urandom % 4) == 0;
            if (master) begin
                pulse_req();
                wait_ticks(($urandom % 16) + 1);
                if ($urandom % 2) pulse_req();
                wait_ticks(($urandom % 6) + 1);
            end else begin
                hold(1'b0, ($urandom % 8) + 8);
                hold(1'b1, ($urandom % 3) + 1);
                if ($urandom % 3 != 0) send55();
                if ($urandom % 4 == 0) pulse_req();
                hold(1'b1, ($urandom % 3) + 1);
            end
        end
        @(negedge clk); master = 1'b0;
        wait_ticks(20);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule